// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Shifter

This block drives a three-wire serial EEPROM link. The link has one clock output, one data line (split into drive value, drive enable and a sampled input) and a chip select that the host drives itself. Software first loads the data register. It then writes an 8-bit control word, and that write starts one burst of 0 to 8 serial clocks. In a write burst the bits leave from the top of the data register, most significant first. In a read burst the bits come back from the device, most significant first, and fill the low end of the data register.

Two options set what happens at the end of a burst. The first releases the data line the moment the last rising clock edge occurs. The second applies only when the line is released: the busy flag then stays high until the device pulls the line from low to high, which it does to report that an internal write has finished. A single-cycle interrupt pulse marks every fall of busy. Longer operations are built by the host as a series of bursts inside one chip-select window.

The serial clock rate comes from a system clock frequency and a target rate, nominally 500 kHz. The clock idles low. The block changes outgoing data while the clock is low and samples incoming data at each rising edge. The sampled input passes through a parameterised synchronizer first.

Top module: `uwire_shifter`

## Requirements
- R1: A control write accepted while idle raises `busy` on the next clock. From then on `stat_q` reads {wait-ready in bit 7, busy in bit 6, release in bit 5, read in bit 4, clamped count in bits 3:0}.
- R2: A burst issues exactly the clamped count of `sck` rising edges. Counts above DATA_W (8) are clamped to DATA_W. `sck` is low whenever `busy` is low, and each serial bit lasts 2*HALF_DIV system clocks, so a burst of n>0 bits without a ready wait keeps `busy` high for 2*n*HALF_DIV cycles.
- R3: In a write burst (read bit 0) `sd_o` carries the data register MSB first: bit DATA_W-1 at the first rising edge, then the next lower bit at each following edge. `sd_o` never changes while `sck` is high, and `sd_oe` is 1 at every rising edge except as R6 allows.
- R4: In a read burst (read bit 1) `sd_oe` stays 0. The n sampled bits enter MSB first and sit right-justified in `dat_q[n-1:0]`, with every higher bit of `dat_q` cleared.
- R5: A count of 0 issues no clock and keeps `busy` high for exactly one cycle. It then sets `sd_oe` to the inverse of the release bit.
- R6: When the release bit is 1, `sd_oe` is already 0 at the last rising edge of a burst. When it is 0, a write burst keeps driving after the burst ends (`sd_oe`=1).
- R7: With both wait-ready and release set, `busy` stays high after the burst until a 0-to-1 change is seen on the synchronized `sd_i`. `busy` falls on the third system clock edge after `sd_i` rises (two synchronizer stages plus the edge detector). With release at 0, wait-ready has no effect on the timing.
- R8: `irq` is high for exactly the one cycle in which `busy` has just fallen.
- R9: Control and data-register writes made while `busy` is high are ignored: bit count, timing, `stat_q` and `dat_q` are unchanged.
- R10: A data-register write while idle appears on `dat_q` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control-word write strobe; starts a burst |
| ctl_wdata | input | 8 | Control word {wait-ready, unused, release, read, count[3:0]} |
| dat_wr | input | 1 | Data-register write strobe |
| dat_wdata | input | DATA_W | Data-register write value |
| dat_q | output | DATA_W | Data-register contents |
| stat_q | output | 8 | Status and configuration readback |
| busy | output | 1 | High while a burst or ready wait is in progress |
| irq | output | 1 | One-cycle pulse when busy falls |
| sck | output | 1 | Serial clock, idles low |
| sd_o | output | 1 | Serial data drive value |
| sd_oe | output | 1 | Serial data drive enable |
| sd_i | input | 1 | Serial data line as seen at the pin |

## Verification
The bench aims at these corner cases:
- An over-range count of 15 must produce eight clocks. A design that does not clamp would clock fifteen times.
- A count of zero must produce no clocks, keep `busy` high for one cycle, and leave the line driven or released as the release bit says.
- A 3-bit read over a data register preloaded with all ones must return clean upper zeros. A design that shifts without clearing first would leave stale ones in `dat_q`.
- A write with release set must show `sd_oe` already low at the last rising edge.
- Wait-ready must extend `busy` by exactly the synchronizer latency after the device raises the line, and must do nothing when the release bit is clear.
- A control and data write injected mid-burst must change neither the clock count nor the register contents.

// File: rtl/uw_pkg.sv
package uw_pkg;

   typedef enum logic [2:0] {
      UW_IDLE = 3'd0,
      UW_LOW  = 3'd1,
      UW_HIGH = 3'd2,
      UW_WAIT = 3'd3,
      UW_FIN  = 3'd4
   } uw_state_e;

   // control / status word; bit order is decoded by software
   typedef struct packed {
      logic       wfr;
      logic       busy;
      logic       hiz;
      logic       rd;
      logic [3:0] cnt;
   } uw_ctl_t;

   localparam int unsigned UW_CTL_W = $bits(uw_ctl_t);

endpackage

// File: rtl/uw_in_sync.sv
module uw_in_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic rise
);
   logic q_prev;

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else if (STAGES == 1) chain <= d;
            else chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_prev <= 1'b0;
      else        q_prev <= q;
   end

   assign rise = q & ~q_prev;
endmodule

// File: rtl/uw_bit_timer.sv
module uw_bit_timer #(
   parameter int unsigned HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int unsigned TW = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [TW-1:0] LAST = TW'(HALF - 1);

   logic [TW-1:0] cnt;

   generate
      if (HALF < 1) begin : g_bad_half
         $error("uw_bit_timer: HALF must be at least 1");
      end
   endgenerate

   assign tick = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run||tick) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/uw_datapath.sv
module uw_datapath #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_data,
   input  logic              start_rd,
   input  logic              start_tx,
   input  logic              rx_shift,
   input  logic              rx_bit,
   input  logic              tx_shift,
   output logic [DATA_W-1:0] dat_q,
   output logic              tx_msb
);
   logic [DATA_W-1:0] data_r;
   logic [DATA_W-1:0] tx_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        data_r <= '0;
      else if (host_wr)  data_r <= host_data;
      else if (start_rd) data_r <= '0;
      else if (rx_shift) begin
         if (DATA_W == 1) data_r <= rx_bit;
         else             data_r <= {data_r[DATA_W-2:0], rx_bit};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tx_r <= '0;
      else if (start_tx) tx_r <= data_r;
      else if (tx_shift) tx_r <= tx_r << 1;
   end

   assign dat_q  = data_r;
   assign tx_msb = tx_r[DATA_W-1];
endmodule

// File: rtl/uwire_shifter.sv
module uwire_shifter #(
   parameter int unsigned SYS_CLK_HZ  = 4_000_000,
   parameter int unsigned SCK_HZ      = 500_000,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [7:0]        ctl_wdata,
   input  logic              dat_wr,
   input  logic [DATA_W-1:0] dat_wdata,
   output logic [DATA_W-1:0] dat_q,
   output logic [7:0]        stat_q,
   output logic              busy,
   output logic              irq,
   output logic              sck,
   output logic              sd_o,
   output logic              sd_oe,
   input  logic              sd_i
);
   import uw_pkg::*;

   localparam int unsigned HALF_DIV = SYS_CLK_HZ / (2 * SCK_HZ);
   localparam logic [3:0]  MAX_CNT  = 4'(DATA_W);

   generate
      if (DATA_W < 1 || DATA_W > 15) begin : g_bad_width
         $error("uwire_shifter: DATA_W must be 1..15");
      end
      if (HALF_DIV <= SYNC_STAGES) begin : g_bad_rate
         $error("uwire_shifter: half bit period must exceed synchronizer depth");
      end
      if (UW_CTL_W != 8) begin : g_bad_ctl
         $error("uwire_shifter: control word must be 8 bits");
      end
   endgenerate

   uw_state_e  state;
   uw_ctl_t    cfg;
   uw_ctl_t    wr_ctl;
   logic [3:0] bits_left;
   logic [3:0] cnt_cl;
   logic       oe_r;
   logic       irq_r;
   logic       accept;
   logic       tick;
   logic       in_q;
   logic       in_rise;
   logic       start_rd;
   logic       start_tx;
   logic       rx_shift;
   logic       tx_shift;
   logic       tx_msb;

   assign wr_ctl = uw_ctl_t'(ctl_wdata);
   assign cnt_cl = (wr_ctl.cnt > MAX_CNT) ? MAX_CNT : wr_ctl.cnt;
   assign accept = ctl_wr && (state == UW_IDLE);

   uw_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (sd_i),
      .q    (in_q),
      .rise (in_rise)
   );

   uw_bit_timer #(.HALF(HALF_DIV)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  ((state == UW_LOW) || (state == UW_HIGH)),
      .tick (tick)
   );

   assign start_tx = accept && !wr_ctl.rd && (cnt_cl != 4'd0);
   assign start_rd = accept &&  wr_ctl.rd && (cnt_cl != 4'd0);
   assign rx_shift = (state == UW_LOW)  && tick && cfg.rd;
   assign tx_shift = (state == UW_HIGH) && tick && !cfg.rd && (bits_left != 4'd0);

   uw_datapath #(.DATA_W(DATA_W)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_wr  (dat_wr && (state == UW_IDLE)),
      .host_data(dat_wdata),
      .start_rd (start_rd),
      .start_tx (start_tx),
      .rx_shift (rx_shift),
      .rx_bit   (in_q),
      .tx_shift (tx_shift),
      .dat_q    (dat_q),
      .tx_msb   (tx_msb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= UW_IDLE;
         cfg       <= '0;
         bits_left <= '0;
         oe_r      <= 1'b0;
         irq_r     <= 1'b0;
      end else begin
         irq_r <= 1'b0;
         unique case (state)
            UW_IDLE: begin
               if (accept) begin
                  cfg       <= '{wfr: wr_ctl.wfr, busy: 1'b0, hiz: wr_ctl.hiz,
                                 rd: wr_ctl.rd, cnt: cnt_cl};
                  bits_left <= cnt_cl;
                  if (cnt_cl == 4'd0) begin
                     oe_r  <= !wr_ctl.hiz;
                     state <= (wr_ctl.wfr && wr_ctl.hiz) ? UW_WAIT : UW_FIN;
                  end else begin
                     oe_r  <= !wr_ctl.rd;
                     state <= UW_LOW;
                  end
               end
            end
            UW_LOW: begin
               if (tick) begin
                  state     <= UW_HIGH;
                  bits_left <= bits_left - 1'b1;
                  if (bits_left == 4'd1 && cfg.hiz) oe_r <= 1'b0;
               end
            end
            UW_HIGH: begin
               if (tick) begin
                  if (bits_left != 4'd0) begin
                     state <= UW_LOW;
                  end else if (cfg.wfr && cfg.hiz) begin
                     state <= UW_WAIT;
                  end else begin
                     state <= UW_IDLE;
                     irq_r <= 1'b1;
                  end
               end
            end
            UW_WAIT: begin
               if (in_rise) begin
                  state <= UW_IDLE;
                  irq_r <= 1'b1;
               end
            end
            UW_FIN: begin
               state <= UW_IDLE;
               irq_r <= 1'b1;
            end
            default: state <= UW_IDLE;
         endcase
      end
   end

   assign busy   = (state != UW_IDLE);
   assign sck    = (state == UW_HIGH);
   assign irq    = irq_r;
   assign sd_o   = tx_msb;
   assign sd_oe  = oe_r;
   assign stat_q = {cfg.wfr, busy, cfg.hiz, cfg.rd, cfg.cnt};

endmodule

// File: rtl/uw_checker.sv
module uw_checker #(
   parameter int unsigned DATA_W = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       irq,
   input logic       sck,
   input logic       sd_o,
   input logic       sd_oe,
   input logic [7:0] stat_q
);
   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck); // R2

   AST_CNT_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (stat_q[3:0] <= 4'(DATA_W))); // R2

   AST_TX_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(sd_o)); // R3

   AST_RD_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && stat_q[4] && (stat_q[3:0] != 4'd0)) |-> !sd_oe); // R4

   AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> irq); // R8

   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R8

   AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !busy); // R8

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(stat_q)); // R9
endmodule

bind uwire_shifter uw_checker #(.DATA_W(DATA_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .busy  (busy),
   .irq   (irq),
   .sck   (sck),
   .sd_o  (sd_o),
   .sd_oe (sd_oe),
   .stat_q(stat_q)
);

// File: tb/tb_uwire_shifter.sv
module tb_uwire_shifter;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 4;
   localparam int SYNC       = 2;
   localparam int DW         = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_wr = 1'b0;
   logic [7:0]    ctl_wdata = '0;
   logic          dat_wr = 1'b0;
   logic [DW-1:0] dat_wdata = '0;
   logic [DW-1:0] dat_q;
   logic [7:0]    stat_q;
   logic          busy, irq, sck, sd_o, sd_oe, sd_i;

   // device model
   logic          rd_txn = 1'b0;
   logic          wait_level = 1'b0;
   logic [7:0]    pat_r = '0;
   int            npat = 0;
   int            ridx = 0;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   assign sd_i = (rd_txn && ridx < npat) ? pat_r[npat-1-ridx] : wait_level;

   uwire_shifter #(
      .SYS_CLK_HZ (4_000_000),
      .SCK_HZ     (500_000),
      .DATA_W     (DW),
      .SYNC_STAGES(SYNC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_q(dat_q), .stat_q(stat_q),
      .busy(busy), .irq(irq), .sck(sck), .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int clampn(input logic [3:0] c);
      return (c > DW) ? DW : int'(c);
   endfunction

   function automatic int exp_busy(input int n, input logic wfr, input logic hiz, input int dwait);
      if (wfr && hiz) return 2*n*HALF + dwait + SYNC;
      if (n == 0)     return 1;
      return 2*n*HALF;
   endfunction

   task automatic run_txn(input logic [3:0] cnt, input logic rd, input logic hiz,
                          input logic wfr, input logic [7:0] data, input logic [7:0] pat,
                          input int dwait, input bit poke);
      int n, busyc, rises, ebusy;
      logic [7:0] txbits, mask;
      logic prev_sck;
      bit oe_bad;
      n = clampn(cnt);
      mask = (n == 0) ? 8'h00 : 8'(9'h100 >> (8-n)) - 8'h01;
      if (n == 8) mask = 8'hFF;
      @(negedge clk);
      dat_wr = 1'b1; dat_wdata = data;
      @(negedge clk);
      dat_wr = 1'b0;
      chk("R10 data write", dat_q, data);
      rd_txn = rd; npat = n; pat_r = pat; ridx = 0; wait_level = 1'b0;
      ctl_wdata = {wfr, 1'b0, hiz, rd, cnt};
      ctl_wr = 1'b1;
      @(negedge clk);
      ctl_wr = 1'b0;
      chk("R1 busy rises", busy, 1);
      chk("R1 status word", stat_q, {wfr, 1'b1, hiz, rd, 4'(n)});
      ebusy = exp_busy(n, wfr, hiz, dwait);
      busyc = 0; rises = 0; prev_sck = 1'b0; txbits = '0; oe_bad = 0;
      while (busy && busyc < 5000) begin
         busyc++;
         if (sck && !prev_sck) begin
            rises++;
            txbits = {txbits[6:0], sd_o};
            if (sd_oe !== (rd ? 1'b0 : ((rises == n && hiz) ? 1'b0 : 1'b1))) oe_bad = 1;
            ridx++;
         end
         prev_sck = sck;
         if (wfr && hiz && busyc == 2*n*HALF + dwait) wait_level = 1'b1;
         if (poke && busyc == 3) begin
            ctl_wr = 1'b1; ctl_wdata = 8'h08; dat_wr = 1'b1; dat_wdata = ~data;
         end else if (poke && busyc == 4) begin
            ctl_wr = 1'b0; dat_wr = 1'b0;
         end
         @(negedge clk);
      end
      chk(poke ? "R9 busy length with mid-burst write" :
          ((wfr && hiz) ? "R7 ready-wait busy length" :
           (n == 0 ? "R5 zero-count busy length" : "R2 busy length")), busyc, ebusy);
      chk(poke ? "R9 clock count with mid-burst write" : "R2 rising edge count", rises, n);
      chk("R8 irq on busy fall", irq, 1);
      chk("R3 R6 drive enable at rising edges", oe_bad, 0);
      if (!rd && n > 0) chk("R3 serial bits MSB first", txbits & mask, (data >> (8-n)) & mask);
      if (n == 0) chk("R5 zero-count line state", sd_oe, !hiz);
      else        chk("R6 line state after burst", sd_oe, rd ? 1'b0 : !hiz);
      if (rd && n > 0) chk("R4 right-justified read", dat_q, pat & mask);
      else             chk(poke ? "R9 data unchanged" : "R4 data kept", dat_q, data);
      @(negedge clk);
      chk("R8 irq one cycle", irq, 0);
      wait_level = 1'b0; rd_txn = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd1234);
      repeat (3) @(negedge clk);
      chk("R2 reset sck", sck, 0);
      chk("R1 reset busy", busy, 0);
      chk("R8 reset irq", irq, 0);
      chk("R6 reset drive", sd_oe, 0);
      chk("R10 reset data", dat_q, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_txn(4'd8,  1'b0, 1'b0, 1'b0, 8'hA5, 8'h00, 0, 0); // R3 full write
      run_txn(4'd8,  1'b1, 1'b0, 1'b0, 8'h00, 8'h3C, 0, 0); // R4 full read
      run_txn(4'd3,  1'b1, 1'b1, 1'b0, 8'hFF, 8'h05, 0, 0); // R4 upper bits cleared
      run_txn(4'd15, 1'b0, 1'b0, 1'b0, 8'h96, 8'h00, 0, 0); // R2 clamp
      run_txn(4'd0,  1'b0, 1'b0, 1'b0, 8'h11, 8'h00, 0, 0); // R5 drive
      run_txn(4'd0,  1'b0, 1'b1, 1'b0, 8'h22, 8'h00, 0, 0); // R5 release
      run_txn(4'd5,  1'b0, 1'b1, 1'b0, 8'hC3, 8'h00, 0, 0); // R6 release at last edge
      run_txn(4'd5,  1'b0, 1'b1, 1'b1, 8'h5A, 8'h00, 7, 0); // R7 wait for ready
      run_txn(4'd0,  1'b0, 1'b1, 1'b1, 8'h5A, 8'h00, 4, 0); // R7 wait, no clocks
      run_txn(4'd4,  1'b0, 1'b0, 1'b1, 8'h69, 8'h00, 0, 0); // R7 ignored without release
      run_txn(4'd3,  1'b0, 1'b0, 1'b0, 8'hE1, 8'h00, 0, 1); // R9 mid-burst writes

      for (int i = 0; i < 40; i++) begin
         logic [3:0] c;
         logic r, h, w;
         c = 4'($urandom_range(0, 15));
         r = 1'($urandom());
         h = 1'($urandom());
         w = 1'($urandom());
         run_txn(c, r, h, w, 8'($urandom()), 8'($urandom()), int'($urandom_range(3, 12)), 0);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule